// File: doc/BRIEF.md
# Master-Clock Frequency Select Register with Triple-Write Guard

This block holds the master-clock frequency selection of a timing device behind a register bus. A new selection is accepted only after the same two-bit frequency code has been written to one guarded address three times in a row. Writes or reads to any other address in between cancel the attempt. When the third matching write lands, the block commits the code and raises a one-cycle soft-reset pulse for the rest of the chip. A hard reset always restores the 12.8 MHz selection.

The sequencer is a four-state machine. `ST_IDLE` means no write is pending (count 0). `ST_ONE` and `ST_TWO` mean one or two matching writes have been taken. `ST_SOFTRST` is the commit cycle, in which the soft reset is driven and the count reads 3. The transitions are named as follows. *start*: any guarded write from `ST_IDLE` goes to `ST_ONE`. *restart*: a guarded write whose code differs from the pending code goes to `ST_ONE` from `ST_ONE` or `ST_TWO`. *advance*: a matching write moves `ST_ONE` to `ST_TWO`. *commit*: a matching write moves `ST_TWO` to `ST_SOFTRST`. *abort*: a read or write of another address returns `ST_ONE` or `ST_TWO` to `ST_IDLE`. *release*: `ST_SOFTRST` always moves to `ST_IDLE` after one cycle. A guarded read, or a cycle with no access, holds the state.

A read of the guarded address returns the committed code, the count of consecutive writes and the pending code. The synthesis of the clock itself lies outside this block.

Top module: `twg_guard_reg`

## Requirements
- R1: After hard reset, `freq_id` is 1 (12.8 MHz), `soft_rst` is 0, the count is 0 and the pending code is 1.
- R2: Frequency codes are 0 = 10 MHz, 1 = 12.8 MHz, 2 = 19.2 MHz and 3 = 20 MHz, taken from `wdata[1:0]`. A third consecutive guarded write carrying the same code as the two before it changes `freq_id` to that code at the clock edge that takes the write.
- R3: `soft_rst` is high for exactly the one cycle after the committing edge. During that cycle the count reads 3. In the next cycle the count is 0, and `freq_id` keeps the newly committed code.
- R4: A read or a write of any address other than `GUARD_ADDR` while one or two writes are pending clears the count to 0, and no commit follows from the earlier writes.
- R5: A guarded write whose code differs from the pending code sets the count to 1 and makes the new code the pending one.
- R6: A read of the guarded address leaves the count and the pending code unchanged.
- R7: While `rd_en` is high with `addr` equal to `GUARD_ADDR`, `rdata` shows the committed code in bits [1:0], the count in bits [3:2] and the pending code in bits [5:4], with all upper bits zero. In every other cycle `rdata` is zero.
- R8: Bus accesses in the soft-reset cycle are ignored: they change neither the count nor the pending code.
- R9: `freq_id` changes only in a cycle where `soft_rst` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe, taken at the rising edge |
| rd_en | input | 1 | Read strobe |
| wdata | input | DATA_W | Write data; bits [1:0] carry the frequency code |
| rdata | output | DATA_W | Combinational read data |
| freq_id | output | 2 | Committed frequency code |
| soft_rst | output | 1 | One-cycle soft-reset pulse after a commit |

## Verification
The restart and the commit can be triggered by the same bus write. When a write reaches `ST_TWO`, the machine must choose between them by comparing the new code with the pending one. This is provoked by writing one code twice and then a different code. The result is judged by requiring that `soft_rst` stays low, `freq_id` is unchanged and the readback shows count 1 with the new pending code. A second collision comes from a write issued during the soft-reset cycle itself. There the release must win: the count is 0 afterwards and the pending code is untouched.

// File: rtl/twg_pkg.sv
package twg_pkg;
    localparam int ID_W  = 2;
    localparam int CNT_W = 2;
    localparam int FIELD_W = 3 * ID_W;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ONE     = 2'd1,
        ST_TWO     = 2'd2,
        ST_SOFTRST = 2'd3
    } twg_state_e;

    localparam logic [ID_W-1:0] ID_10M   = 2'd0;
    localparam logic [ID_W-1:0] ID_12M8  = 2'd1;
    localparam logic [ID_W-1:0] ID_19M2  = 2'd2;
    localparam logic [ID_W-1:0] ID_20M   = 2'd3;
    localparam logic [ID_W-1:0] ID_RESET = ID_12M8;
endpackage

// File: rtl/twg_seq.sv
module twg_seq
    import twg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            guard_wr,
    input  logic            other_acc,
    input  logic [ID_W-1:0] wr_id,
    output logic [ID_W-1:0] pend_q,
    output logic [ID_W-1:0] freq_q,
    output logic [CNT_W-1:0] cnt,
    output logic            soft_rst
);
    twg_state_e state_q, state_d;
    logic       commit;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (guard_wr) state_d = ST_ONE;
            end
            ST_ONE: begin
                if (other_acc)                   state_d = ST_IDLE;
                else if (guard_wr && wr_id == pend_q) state_d = ST_TWO;
                else if (guard_wr)               state_d = ST_ONE;
            end
            ST_TWO: begin
                if (other_acc)                   state_d = ST_IDLE;
                else if (guard_wr && wr_id == pend_q) state_d = ST_SOFTRST;
                else if (guard_wr)               state_d = ST_ONE;
            end
            ST_SOFTRST: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign commit = (state_d == ST_SOFTRST) && (state_q != ST_SOFTRST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // pending and committed codes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= ID_RESET;
            freq_q <= ID_RESET;
        end else begin
            if (guard_wr && state_q != ST_SOFTRST) pend_q <= wr_id;
            if (commit)                            freq_q <= wr_id;
        end
    end

    // outputs
    always_comb begin
        soft_rst = 1'b0;
        cnt      = '0;
        unique case (state_q)
            ST_IDLE:    cnt = 2'd0;
            ST_ONE:     cnt = 2'd1;
            ST_TWO:     cnt = 2'd2;
            ST_SOFTRST: begin
                cnt      = 2'd3;
                soft_rst = 1'b1;
            end
            default:    cnt = 2'd0;
        endcase
    end
endmodule

// File: rtl/twg_rdbk.sv
module twg_rdbk
    import twg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic             rd_sel,
    input  logic [ID_W-1:0]  freq,
    input  logic [CNT_W-1:0] cnt,
    input  logic [ID_W-1:0]  pend,
    output logic [DATA_W-1:0] rdata
);
    logic [FIELD_W-1:0] fields;
    assign fields = {pend, cnt, freq};

    generate
        if (DATA_W > FIELD_W) begin : g_pad
            assign rdata = rd_sel ? {{(DATA_W-FIELD_W){1'b0}}, fields} : '0;
        end else begin : g_trim
            assign rdata = rd_sel ? fields[DATA_W-1:0] : '0;
        end
    endgenerate
endmodule

// File: rtl/twg_guard_reg.sv
module twg_guard_reg
    import twg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] GUARD_ADDR = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [ID_W-1:0]   freq_id,
    output logic              soft_rst
);
    logic              hit, guard_wr, other_acc, rd_sel;
    logic [ID_W-1:0]   pend_id;
    logic [CNT_W-1:0]  seq_cnt;
    logic              unused_wdata;

    assign hit       = (addr == GUARD_ADDR);
    assign guard_wr  = wr_en & hit;
    assign other_acc = (wr_en | rd_en) & ~hit;
    assign rd_sel    = rd_en & hit;
    assign unused_wdata = ^wdata[DATA_W-1:ID_W];

    twg_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .guard_wr  (guard_wr),
        .other_acc (other_acc),
        .wr_id     (wdata[ID_W-1:0]),
        .pend_q    (pend_id),
        .freq_q    (freq_id),
        .cnt       (seq_cnt),
        .soft_rst  (soft_rst)
    );

    twg_rdbk #(.DATA_W(DATA_W)) u_rdbk (
        .rd_sel (rd_sel),
        .freq   (freq_id),
        .cnt    (seq_cnt),
        .pend   (pend_id),
        .rdata  (rdata)
    );
endmodule

// File: rtl/twg_guard_chk.sv
module twg_guard_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] GUARD_ADDR = 8'h3C
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [1:0]        freq_id,
    input logic              soft_rst,
    input logic [1:0]        seq_cnt
);
    p_commit_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_rst) |-> ($past(wr_en) && $past(addr) == GUARD_ADDR
                             && freq_id == $past(wdata[1:0])));

    p_pulse_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!soft_rst && seq_cnt == 2'd0));

    p_pulse_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> seq_cnt == 2'd3);

    p_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && addr != GUARD_ADDR && !soft_rst) |=> seq_cnt == 2'd0);

    p_guard_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == GUARD_ADDR && !soft_rst) |=> $stable(seq_cnt));

    p_rdata_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && addr == GUARD_ADDR) |-> rdata == '0);

    p_freq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(freq_id) |-> soft_rst);
endmodule

bind twg_guard_reg twg_guard_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GUARD_ADDR(GUARD_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .freq_id(freq_id), .soft_rst(soft_rst),
    .seq_cnt(seq_cnt)
);

// File: tb/sim_twg_guard_reg.sv
module sim_twg_guard_reg;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] G  = 8'h3C;
    localparam logic [7:0] OT = 8'h05;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] freq_id;
    logic       soft_rst;

    int vectors = 0;
    int fails   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twg_guard_reg u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .freq_id(freq_id), .soft_rst(soft_rst)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] fld(input logic [1:0] p, input logic [1:0] c, input logic [1:0] f);
        return {2'b00, p, c, f};
    endfunction

    // write crossing one edge; returns at the following negedge
    task automatic do_write(input logic [7:0] a, input logic [1:0] id);
        @(negedge clk);
        addr = a; wdata = {6'b101010, id}; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // read crossing one edge
    task automatic do_read(input logic [7:0] a);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // read without crossing an edge
    task automatic peek(output logic [7:0] v);
        addr = G; rd_en = 1'b1;
        #1;
        v = rdata;
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        @(negedge clk); #1;
        chk("R1 freq", {6'b0, freq_id}, 8'd1);
        chk("R1 soft_rst", {7'b0, soft_rst}, 8'd0);
        peek(v);
        chk("R1/R7 readback", v, fld(2'd1, 2'd0, 2'd1));
    endtask

    task automatic t_commit;
        logic [7:0] v;
        do_write(G, 2'd2); #1; peek(v);
        chk("R2 count after 1", v, fld(2'd2, 2'd1, 2'd1));
        do_write(G, 2'd2); #1; peek(v);
        chk("R9 count after 2, no commit", v, fld(2'd2, 2'd2, 2'd1));
        do_write(G, 2'd2); #1;
        chk("R2 freq committed", {6'b0, freq_id}, 8'd2);
        chk("R3 soft_rst high", {7'b0, soft_rst}, 8'd1);
        peek(v);
        chk("R3 count 3 in pulse", v, fld(2'd2, 2'd3, 2'd2));
        @(negedge clk); #1;
        chk("R3 soft_rst one cycle", {7'b0, soft_rst}, 8'd0);
        peek(v);
        chk("R3 count cleared, freq kept", v, fld(2'd2, 2'd0, 2'd2));
    endtask

    task automatic t_abort_write;
        logic [7:0] v;
        do_write(G, 2'd3);
        do_write(G, 2'd3);
        do_write(OT, 2'd3); #1; peek(v);
        chk("R4 write elsewhere clears count", v, fld(2'd3, 2'd0, 2'd2));
        do_write(G, 2'd3); #1;
        chk("R4 no commit after abort", {7'b0, soft_rst}, 8'd0);
        peek(v);
        chk("R4 fresh count 1", v, fld(2'd3, 2'd1, 2'd2));
        do_write(G, 2'd3);
        do_write(G, 2'd3); #1;
        chk("R2 commit 20 MHz code", {6'b0, freq_id}, 8'd3);
        @(negedge clk);
    endtask

    task automatic t_abort_read;
        logic [7:0] v;
        do_write(G, 2'd0);
        do_write(G, 2'd0);
        do_read(OT); #1; peek(v);
        chk("R4 read elsewhere clears count", v, fld(2'd0, 2'd0, 2'd3));
        do_write(G, 2'd0); #1;
        chk("R9 freq unchanged after abort", {6'b0, freq_id}, 8'd3);
        peek(v);
        chk("R4 count restarts at 1", v, fld(2'd0, 2'd1, 2'd3));
        do_read(OT);
    endtask

    task automatic t_restart;
        logic [7:0] v;
        do_write(G, 2'd1);
        do_write(G, 2'd1);
        do_write(G, 2'd2); #1;
        chk("R5 no pulse on differing code", {7'b0, soft_rst}, 8'd0);
        chk("R5 freq unchanged", {6'b0, freq_id}, 8'd3);
        peek(v);
        chk("R5 restart count 1 new code", v, fld(2'd2, 2'd1, 2'd3));
        do_write(G, 2'd2);
        do_write(G, 2'd2); #1;
        chk("R5 commit after restart", {6'b0, freq_id}, 8'd2);
        @(negedge clk);
    endtask

    task automatic t_guard_read;
        logic [7:0] v;
        do_write(G, 2'd0);
        do_read(G);
        do_read(G); #1; peek(v);
        chk("R6 guarded reads keep count", v, fld(2'd0, 2'd1, 2'd2));
        do_write(G, 2'd0);
        do_read(G);
        do_write(G, 2'd0); #1;
        chk("R6 commit across guarded reads", {6'b0, freq_id}, 8'd0);
        @(negedge clk);
    endtask

    task automatic t_pulse_ignore;
        logic [7:0] v;
        do_write(G, 2'd1);
        do_write(G, 2'd1);
        do_write(G, 2'd1);
        // now in pulse cycle: issue a guarded write across its edge
        addr = G; wdata = 8'h03; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; #1;
        peek(v);
        chk("R8 write in pulse ignored", v, fld(2'd1, 2'd0, 2'd1));
    endtask

    task automatic t_rdata_idle;
        addr = G; rd_en = 1'b0; #1;
        chk("R7 rdata zero without read", rdata, 8'h00);
        addr = OT; rd_en = 1'b1; #1;
        chk("R7 rdata zero other address", rdata, 8'h00);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_hard_reset;
        logic [7:0] v;
        do_write(G, 2'd3);
        do_write(G, 2'd3);
        do_write(G, 2'd3);
        @(negedge clk);
        do_write(G, 2'd2);
        rst_n = 1'b0; #1;
        chk("R1 hard reset restores 12.8", {6'b0, freq_id}, 8'd1);
        peek(v);
        chk("R1 hard reset readback", v, fld(2'd1, 2'd0, 2'd1));
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_commit();
        t_abort_write();
        t_abort_read();
        t_restart();
        t_guard_read();
        t_pulse_ignore();
        t_rdata_idle();
        t_hard_reset();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule